// File: doc/BRIEF.md
# Branch program-counter sequencer

This block owns the program counter (PC) and stack pointer (SP) of a small byte-wide processor while it carries out control-transfer instructions. A decoder that sits outside the block presents an operation kind, an optional condition, the four status flags and the 16-bit HL pair, then pulses `start`. The block then works through the instruction over a byte-wide memory port. It fetches the 16-bit target from the two bytes after the opcode, low byte first. For a call it pushes the return address onto a stack that grows downward. For a return it pops the saved address. When the operation is finished it signals `done` for one cycle.

Four operation kinds are supported: jump, call, return, and load-PC-from-HL. The first three can be made conditional on one of eight flag tests. When the test fails, the PC steps over the instruction and the memory port stays idle. The state machine has eight states. IDLE waits for `start` and decides in the same edge whether the operation is taken. TGT_LO and TGT_HI read the two target bytes. PUSH_HI and PUSH_LO write the return address. POP_LO and POP_HI read the saved address. DONE signals completion. The transitions are as follows:
- IDLE→DONE for HL loads and for skipped operations.
- IDLE→TGT_LO for a taken jump or call.
- IDLE→POP_LO for a taken return.
- TGT_LO→TGT_HI.
- TGT_HI→DONE for a jump, and TGT_HI→PUSH_HI for a call.
- PUSH_HI→PUSH_LO→DONE.
- POP_LO→POP_HI→DONE.
- DONE→IDLE.

Top module: `branch_seq`

## Requirements
- R1: While reset is held and after it is released, `pc` equals PC_RESET, `sp` equals SP_RESET, `busy` and `done` are low, and neither `mem_rd` nor `mem_wr` is asserted.
- R2: When `cond_en` is high, the operation is taken only if the test picked by `cond_sel` holds: 0 zero clear, 1 zero set, 2 carry clear, 3 carry set, 4 parity clear (odd), 5 parity set (even), 6 sign clear (positive), 7 sign set (minus). The flags are sampled on the edge that accepts `start`. When `cond_en` is low the operation is always taken.
- R3: A taken jump (`op_kind` 0) reads the low target byte at PC+1 and the high byte at PC+2, then loads the PC with {high, low}. SP does not change.
- R4: A taken call (`op_kind` 1) fetches the target as in R3. It then writes the high byte of PC+3 at SP−1 and, in the next cycle, the low byte at SP−2. Finally it sets PC to the target and lowers SP by 2.
- R5: A taken return (`op_kind` 2) reads the low byte at SP and the high byte at SP+1, loads the PC with {high, low}, and raises SP by 2.
- R6: A skipped operation adds 3 to the PC for a jump or call and 1 for a return. It leaves SP unchanged and makes no memory access.
- R7: Load-from-HL (`op_kind` 3) sets PC to `hl_val`, with H as the high byte, and ignores the condition inputs. SP does not change and no memory access is made.
- R8: The time from the accepting edge to the end of the `done` cycle is 1 cycle for load-from-HL and skipped operations, 3 for a jump, 3 for a return and 5 for a call.
- R9: A `start` that arrives while `busy` is high is ignored. It does not change the operation in progress or its result.
- R10: All PC and SP address arithmetic wraps modulo 2^16, for both operand fetch and stack accesses.
- R11: `busy` is high from the cycle after the accepting edge through the `done` cycle. `done` lasts exactly one cycle. The PC changes only on the edge that raises `done`.
- R12: `mem_rd` and `mem_wr` are never high together, and neither is high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| op_kind | input | 2 | 0 jump, 1 call, 2 return, 3 load PC from HL |
| cond_en | input | 1 | Make the operation conditional |
| cond_sel | input | 3 | Flag test selector (encoding in R2) |
| flag_s | input | 1 | Sign flag |
| flag_z | input | 1 | Zero flag |
| flag_p | input | 1 | Parity flag (1 = even) |
| flag_c | input | 1 | Carry flag |
| hl_val | input | 16 | HL pair, H in bits 15:8 |
| mem_rdata | input | 8 | Read data, valid in the same cycle as `mem_rd` |
| mem_addr | output | 16 | Byte address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest cases to reach from the ports are the ones where an address crosses zero. One is a stack push that straddles 0x0000 and 0xFFFF. Another is a later pop that must read its bytes back across that same seam. A third is an operand fetch whose two bytes lie on either side of the top of memory. The bench reaches these cases by starting the stack pointer at 0x0001 through the reset parameter, so the very first call wraps. It then uses an HL load to place the PC at 0xFFFE before a jump. Calls are also nested one level deep, so the second push lands in ordinary addresses and the two returns unwind in the correct order.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    // Width of the flag test selector (eight tests over four flags).
    localparam int unsigned COND_W = 3;

    typedef enum logic [1:0] {
        OP_JUMP    = 2'd0,
        OP_CALL    = 2'd1,
        OP_RET     = 2'd2,
        OP_LOAD_HL = 2'd3
    } bseq_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TGT_LO,
        ST_TGT_HI,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_POP_LO,
        ST_POP_HI,
        ST_DONE
    } bseq_state_e;

    // Memory address source.
    typedef enum logic [2:0] {
        AS_PC_P1,
        AS_PC_P2,
        AS_SP_M1,
        AS_SP_M2,
        AS_SP_P0,
        AS_SP_P1
    } bseq_asel_e;

    // Next-PC source.
    typedef enum logic [2:0] {
        PS_HOLD,
        PS_HL,
        PS_SKIP_LONG,
        PS_SKIP_SHORT,
        PS_RDATA_LO,
        PS_TARGET
    } bseq_psel_e;

    // Stack pointer update.
    typedef enum logic [1:0] {
        SS_HOLD,
        SS_DOWN2,
        SS_UP2
    } bseq_ssel_e;

endpackage

// File: rtl/bseq_cond.sv
// Flag test: for flag g, even selector 2g tests "clear", odd 2g+1 tests "set".
module bseq_cond #(
    parameter int unsigned N_FLAGS = 4,
    parameter int unsigned SEL_W   = $clog2(2 * N_FLAGS)
) (
    input  logic [N_FLAGS-1:0] flag_vec,
    input  logic [SEL_W-1:0]   sel,
    output logic               hit
);
    localparam int unsigned N_TESTS = 2 * N_FLAGS;

    logic [N_TESTS-1:0] tests;

    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
        assign tests[2*g]   = ~flag_vec[g];
        assign tests[2*g+1] =  flag_vec[g];
    end

    assign hit = tests[sel];

endmodule

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
    import bseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  bseq_op_e   op,
    input  logic       take,
    output logic       busy,
    output logic       done,
    output logic       mem_rd,
    output logic       mem_wr,
    output bseq_asel_e asel,
    output bseq_psel_e psel,
    output bseq_ssel_e ssel,
    output logic       lat_lo,
    output logic       lat_hi,
    output logic       wsel_hi
);
    bseq_state_e state_q, state_d;
    bseq_op_e    op_q;
    logic        accept;

    assign accept = (state_q == ST_IDLE) && start;

    // State register and the latched operation kind.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_JUMP;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_q <= op;
            end
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (op == OP_LOAD_HL || !take) begin
                        state_d = ST_DONE;
                    end else if (op == OP_RET) begin
                        state_d = ST_POP_LO;
                    end else begin
                        state_d = ST_TGT_LO;
                    end
                end
            end
            ST_TGT_LO:  state_d = ST_TGT_HI;
            ST_TGT_HI:  state_d = (op_q == OP_CALL) ? ST_PUSH_HI : ST_DONE;
            ST_PUSH_HI: state_d = ST_PUSH_LO;
            ST_PUSH_LO: state_d = ST_DONE;
            ST_POP_LO:  state_d = ST_POP_HI;
            ST_POP_HI:  state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath controls.
    always_comb begin
        busy    = (state_q != ST_IDLE);
        done    = 1'b0;
        mem_rd  = 1'b0;
        mem_wr  = 1'b0;
        asel    = AS_PC_P1;
        psel    = PS_HOLD;
        ssel    = SS_HOLD;
        lat_lo  = 1'b0;
        lat_hi  = 1'b0;
        wsel_hi = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (op == OP_LOAD_HL) begin
                        psel = PS_HL;
                    end else if (!take) begin
                        psel = (op == OP_RET) ? PS_SKIP_SHORT : PS_SKIP_LONG;
                    end
                end
            end
            ST_TGT_LO: begin
                mem_rd = 1'b1;
                asel   = AS_PC_P1;
                lat_lo = 1'b1;
            end
            ST_TGT_HI: begin
                mem_rd = 1'b1;
                asel   = AS_PC_P2;
                lat_hi = 1'b1;
                if (op_q == OP_JUMP) begin
                    psel = PS_RDATA_LO;
                end
            end
            ST_PUSH_HI: begin
                mem_wr  = 1'b1;
                asel    = AS_SP_M1;
                wsel_hi = 1'b1;
            end
            ST_PUSH_LO: begin
                mem_wr = 1'b1;
                asel   = AS_SP_M2;
                psel   = PS_TARGET;
                ssel   = SS_DOWN2;
            end
            ST_POP_LO: begin
                mem_rd = 1'b1;
                asel   = AS_SP_P0;
                lat_lo = 1'b1;
            end
            ST_POP_HI: begin
                mem_rd = 1'b1;
                asel   = AS_SP_P1;
                psel   = PS_RDATA_LO;
                ssel   = SS_UP2;
            end
            ST_DONE: begin
                done = 1'b1;
            end
            default: begin
                done = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bseq_datapath.sv
module bseq_datapath
    import bseq_pkg::*;
#(
    parameter int unsigned            BYTE_W    = 8,
    parameter int unsigned            ADDR_W    = 2 * BYTE_W,
    parameter logic [ADDR_W-1:0]      PC_RESET  = '0,
    parameter logic [ADDR_W-1:0]      SP_RESET  = '0,
    parameter int unsigned            LONG_LEN  = 3,
    parameter int unsigned            SHORT_LEN = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bseq_asel_e        asel,
    input  bseq_psel_e        psel,
    input  bseq_ssel_e        ssel,
    input  logic              lat_lo,
    input  logic              lat_hi,
    input  logic              wsel_hi,
    input  logic [ADDR_W-1:0] hl_val,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] sp
);
    localparam logic [ADDR_W-1:0] ONE        = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] TWO        = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] STEP_LONG  = ADDR_W'(LONG_LEN);
    localparam logic [ADDR_W-1:0] STEP_SHORT = ADDR_W'(SHORT_LEN);

    logic [ADDR_W-1:0] pc_q, pc_d, sp_q, sp_d, ret_addr;
    logic [BYTE_W-1:0] lo_q, hi_q;

    // PC still addresses the call opcode while the return address is pushed.
    assign ret_addr = pc_q + STEP_LONG;

    always_comb begin
        unique case (asel)
            AS_PC_P1: mem_addr = pc_q + ONE;
            AS_PC_P2: mem_addr = pc_q + TWO;
            AS_SP_M1: mem_addr = sp_q - ONE;
            AS_SP_M2: mem_addr = sp_q - TWO;
            AS_SP_P0: mem_addr = sp_q;
            AS_SP_P1: mem_addr = sp_q + ONE;
            default:  mem_addr = pc_q;
        endcase
    end

    assign mem_wdata = wsel_hi ? ret_addr[ADDR_W-1 -: BYTE_W] : ret_addr[BYTE_W-1:0];

    always_comb begin
        unique case (psel)
            PS_HOLD:       pc_d = pc_q;
            PS_HL:         pc_d = hl_val;
            PS_SKIP_LONG:  pc_d = pc_q + STEP_LONG;
            PS_SKIP_SHORT: pc_d = pc_q + STEP_SHORT;
            PS_RDATA_LO:   pc_d = {mem_rdata, lo_q};
            PS_TARGET:     pc_d = {hi_q, lo_q};
            default:       pc_d = pc_q;
        endcase
    end

    always_comb begin
        unique case (ssel)
            SS_HOLD:  sp_d = sp_q;
            SS_DOWN2: sp_d = sp_q - TWO;
            SS_UP2:   sp_d = sp_q + TWO;
            default:  sp_d = sp_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= PC_RESET;
            sp_q <= SP_RESET;
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            pc_q <= pc_d;
            sp_q <= sp_d;
            if (lat_lo) begin
                lo_q <= mem_rdata;
            end
            if (lat_hi) begin
                hi_q <= mem_rdata;
            end
        end
    end

    assign pc = pc_q;
    assign sp = sp_q;

endmodule

// File: rtl/branch_seq.sv
module branch_seq
    import bseq_pkg::*;
#(
    parameter int unsigned       BYTE_W    = 8,
    localparam int unsigned      ADDR_W    = 2 * BYTE_W,
    parameter logic [ADDR_W-1:0] PC_RESET  = '0,
    parameter logic [ADDR_W-1:0] SP_RESET  = '0,
    parameter int unsigned       LONG_LEN  = 3,
    parameter int unsigned       SHORT_LEN = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op_kind,
    input  logic              cond_en,
    input  logic [COND_W-1:0] cond_sel,
    input  logic              flag_s,
    input  logic              flag_z,
    input  logic              flag_p,
    input  logic              flag_c,
    input  logic [ADDR_W-1:0] hl_val,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] sp,
    output logic              busy,
    output logic              done
);
    localparam int unsigned N_FLAGS = 4;

    logic       cond_hit, take;
    logic       lat_lo, lat_hi, wsel_hi;
    bseq_asel_e asel;
    bseq_psel_e psel;
    bseq_ssel_e ssel;

    // Flag order sets the selector encoding: zero, carry, parity, sign.
    bseq_cond #(
        .N_FLAGS (N_FLAGS),
        .SEL_W   (COND_W)
    ) i_cond (
        .flag_vec ({flag_s, flag_p, flag_c, flag_z}),
        .sel      (cond_sel),
        .hit      (cond_hit)
    );

    assign take = !cond_en || cond_hit;

    bseq_ctrl i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .op      (bseq_op_e'(op_kind)),
        .take    (take),
        .busy    (busy),
        .done    (done),
        .mem_rd  (mem_rd),
        .mem_wr  (mem_wr),
        .asel    (asel),
        .psel    (psel),
        .ssel    (ssel),
        .lat_lo  (lat_lo),
        .lat_hi  (lat_hi),
        .wsel_hi (wsel_hi)
    );

    bseq_datapath #(
        .BYTE_W    (BYTE_W),
        .ADDR_W    (ADDR_W),
        .PC_RESET  (PC_RESET),
        .SP_RESET  (SP_RESET),
        .LONG_LEN  (LONG_LEN),
        .SHORT_LEN (SHORT_LEN)
    ) i_datapath (
        .clk       (clk),
        .rst_n     (rst_n),
        .asel      (asel),
        .psel      (psel),
        .ssel      (ssel),
        .lat_lo    (lat_lo),
        .lat_hi    (lat_hi),
        .wsel_hi   (wsel_hi),
        .hl_val    (hl_val),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .pc        (pc),
        .sp        (sp)
    );

endmodule

// File: rtl/bseq_checker.sv
module bseq_checker #(
    parameter int unsigned ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] pc,
    input logic [ADDR_W-1:0] sp
);
    p_done_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_within_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_pc_moves_at_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pc) |-> done);

    p_rd_wr_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_port_quiet_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr));

    p_push_below_sp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ((mem_addr == sp - ADDR_W'(1)) || (mem_addr == sp - ADDR_W'(2))));

    p_sp_steps_two_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sp) |-> ((sp == $past(sp) + ADDR_W'(2)) || (sp == $past(sp) - ADDR_W'(2))));

endmodule

bind branch_seq bseq_checker #(
    .ADDR_W (ADDR_W)
) i_bseq_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_addr (mem_addr),
    .pc       (pc),
    .sp       (sp)
);

// File: tb/test_branch_seq.sv
module test_branch_seq;

    localparam logic [15:0] PC0 = 16'h0040;
    localparam logic [15:0] SP0 = 16'h0001;
    localparam logic [1:0]  OPJ = 2'd0;
    localparam logic [1:0]  OPC = 2'd1;
    localparam logic [1:0]  OPR = 2'd2;
    localparam logic [1:0]  OPH = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op_kind = 2'd0;
    logic        cond_en = 1'b0;
    logic [2:0]  cond_sel = 3'd0;
    logic        flag_s = 1'b0, flag_z = 1'b0, flag_p = 1'b0, flag_c = 1'b0;
    logic [15:0] hl_val = 16'h0000;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata;
    logic [15:0] pc, sp;
    logic        busy, done;

    logic [7:0]  mem [256];
    logic [15:0] wr_addr_log [4];
    logic [7:0]  wr_data_log [4];
    logic [15:0] rd_addr_log [4];
    int          wr_cnt = 0, rd_cnt = 0;
    int          n_cmp = 0, n_bad = 0, n_cyc = 0;

    branch_seq #(
        .PC_RESET (PC0),
        .SP_RESET (SP0)
    ) i_branch_seq (
        .clk (clk), .rst_n (rst_n), .start (start), .op_kind (op_kind),
        .cond_en (cond_en), .cond_sel (cond_sel),
        .flag_s (flag_s), .flag_z (flag_z), .flag_p (flag_p), .flag_c (flag_c),
        .hl_val (hl_val), .mem_rdata (mem_rdata), .mem_addr (mem_addr),
        .mem_rd (mem_rd), .mem_wr (mem_wr), .mem_wdata (mem_wdata),
        .pc (pc), .sp (sp), .busy (busy), .done (done)
    );

    always #2.5ns clk = ~clk;

    // 256-byte memory aliased across the address space; same-cycle read.
    assign mem_rdata = mem[mem_addr[7:0]];

    always @(posedge clk) begin
        if (mem_wr) begin
            mem[mem_addr[7:0]] <= mem_wdata;
            if (wr_cnt < 4) begin
                wr_addr_log[wr_cnt] = mem_addr;
                wr_data_log[wr_cnt] = mem_wdata;
            end
            wr_cnt = wr_cnt + 1;
        end
        if (mem_rd) begin
            if (rd_cnt < 4) begin
                rd_addr_log[rd_cnt] = mem_addr;
            end
            rd_cnt = rd_cnt + 1;
        end
    end

    always @(posedge clk) begin
        n_cyc = n_cyc + 1;
        if (n_cyc > 150000) begin
            n_cmp = n_cmp + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", n_cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp = n_cmp + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [15:0] a, input logic [7:0] d);
        mem[a[7:0]] <= d;
    endtask

    task automatic do_op(input logic [1:0] op, input logic ce, input logic [2:0] cs,
                         input logic [3:0] szpc, input logic [15:0] hl, output int cyc);
        @(negedge clk);
        op_kind = op;
        cond_en = ce;
        cond_sel = cs;
        {flag_s, flag_z, flag_p, flag_c} = szpc;
        hl_val = hl;
        rd_cnt = 0;
        wr_cnt = 0;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 30) begin
            @(posedge clk);
            @(negedge clk);
            cyc = cyc + 1;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 pc in reset", pc, PC0);
        check("R1 sp in reset", sp, SP0);
        check("R1 busy/done in reset", {busy, done}, 2'b00);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pc after reset", pc, PC0);
        check("R1 port idle after reset", {mem_rd, mem_wr, busy, done}, 4'b0000);
    endtask

    task automatic t_load_hl();
        int c;
        // Condition enabled and failing: must still load (R7).
        do_op(OPH, 1'b1, 3'd1, 4'b0000, 16'h0010, c);
        check("R7 pc from HL", pc, 16'h0010);
        check("R7 sp untouched", sp, SP0);
        check("R7 no memory access", rd_cnt + wr_cnt, 0);
        check("R8 load-HL cycles", c, 1);
        @(negedge clk);
        check("R11 done single and busy drops", {done, busy}, 2'b00);
    endtask

    task automatic t_jump_taken();
        int c;
        poke(16'h0011, 8'h80);
        poke(16'h0012, 8'h00);
        do_op(OPJ, 1'b0, 3'd0, 4'b0000, 16'h0000, c);
        check("R3 jump target", pc, 16'h0080);
        check("R3 sp untouched", sp, SP0);
        check("R3 operand addresses", {rd_addr_log[0], rd_addr_log[1]}, {16'h0011, 16'h0012});
        check("R8 jump cycles", c, 3);
    endtask

    task automatic t_cond_matrix();
        int c;
        poke(16'h0021, 8'h30);
        poke(16'h0022, 8'h00);
        for (int s = 0; s < 8; s++) begin
            for (int v = 0; v < 2; v++) begin
                logic [3:0] fl;
                logic       tk;
                do_op(OPH, 1'b0, 3'd0, 4'b0000, 16'h0020, c);
                fl = v[0] ? 4'b0000 : 4'b1111;
                case (s >> 1)
                    0:       fl[2] = v[0];
                    1:       fl[0] = v[0];
                    2:       fl[1] = v[0];
                    default: fl[3] = v[0];
                endcase
                tk = s[0] ? v[0] : !v[0];
                do_op(OPJ, 1'b1, 3'(s), fl, 16'h0000, c);
                check($sformatf("R2 sel %0d flag %0d pc", s, v), pc, tk ? 16'h0030 : 16'h0023);
                check("R8 conditional jump cycles", c, tk ? 3 : 1);
                if (!tk) begin
                    check("R6 skipped jump no access", rd_cnt + wr_cnt, 0);
                end
            end
        end
    endtask

    task automatic t_call_ret_wrap();
        int c;
        do_op(OPH, 1'b0, 3'd0, 4'b0000, 16'h0050, c);
        poke(16'h0051, 8'h60);
        poke(16'h0052, 8'h00);
        do_op(OPC, 1'b0, 3'd0, 4'b0000, 16'h0000, c);
        check("R4 call target", pc, 16'h0060);
        check("R4 sp lowered (R10 wrap)", sp, 16'hFFFF);
        check("R4 push addresses in order", {wr_addr_log[0], wr_addr_log[1]}, {16'h0000, 16'hFFFF});
        check("R4 push data high then low", {wr_data_log[0], wr_data_log[1]}, {8'h00, 8'h53});
        check("R8 call cycles", c, 5);
        do_op(OPR, 1'b1, 3'd3, 4'b0001, 16'h0000, c);
        check("R5 return pc", pc, 16'h0053);
        check("R5 sp raised", sp, SP0);
        check("R10 pop addresses across zero", {rd_addr_log[0], rd_addr_log[1]}, {16'hFFFF, 16'h0000});
        check("R8 return cycles", c, 3);
    endtask

    task automatic t_skips();
        int c;
        do_op(OPR, 1'b1, 3'd3, 4'b0000, 16'h0000, c);
        check("R6 skipped return pc", pc, 16'h0054);
        check("R6 skipped return sp", sp, SP0);
        check("R8 skipped return cycles", c, 1);
        do_op(OPC, 1'b1, 3'd0, 4'b0100, 16'h0000, c);
        check("R6 skipped call pc", pc, 16'h0057);
        check("R6 skipped call no write", wr_cnt + rd_cnt, 0);
        check("R6 skipped call sp", sp, SP0);
    endtask

    task automatic t_nested();
        int c;
        do_op(OPH, 1'b0, 3'd0, 4'b0000, 16'h0070, c);
        poke(16'h0071, 8'h90);
        poke(16'h0072, 8'h00);
        poke(16'h0091, 8'hA0);
        poke(16'h0092, 8'h00);
        do_op(OPC, 1'b0, 3'd0, 4'b0000, 16'h0000, c);
        do_op(OPC, 1'b0, 3'd0, 4'b0000, 16'h0000, c);
        check("R4 nested call pc", pc, 16'h00A0);
        check("R4 nested sp", sp, 16'hFFFD);
        check("R4 nested push addresses", {wr_addr_log[0], wr_addr_log[1]}, {16'hFFFE, 16'hFFFD});
        check("R4 nested push data", {wr_data_log[0], wr_data_log[1]}, {8'h00, 8'h93});
        do_op(OPR, 1'b0, 3'd0, 4'b0000, 16'h0000, c);
        check("R5 inner return", {pc, sp}, {16'h0093, 16'hFFFF});
        do_op(OPR, 1'b0, 3'd0, 4'b0000, 16'h0000, c);
        check("R5 outer return", {pc, sp}, {16'h0073, SP0});
    endtask

    task automatic t_pc_wrap();
        int c;
        do_op(OPH, 1'b0, 3'd0, 4'b0000, 16'hFFFE, c);
        poke(16'hFFFF, 8'h34);
        poke(16'h0000, 8'h12);
        do_op(OPJ, 1'b0, 3'd0, 4'b0000, 16'h0000, c);
        check("R10 operand fetch wraps", {rd_addr_log[0], rd_addr_log[1]}, {16'hFFFF, 16'h0000});
        check("R10 jump target across wrap", pc, 16'h1234);
    endtask

    task automatic t_busy_ignore();
        int c;
        do_op(OPH, 1'b0, 3'd0, 4'b0000, 16'h00B0, c);
        poke(16'h00B1, 8'hC4);
        poke(16'h00B2, 8'h00);
        @(negedge clk);
        op_kind = OPJ;
        cond_en = 1'b0;
        hl_val = 16'hBEEF;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        op_kind = OPH;
        check("R11 busy after accept", busy, 1'b1);
        c = 1;
        while (!done && c < 30) begin
            @(posedge clk);
            @(negedge clk);
            c = c + 1;
        end
        start = 1'b0;
        check("R9 start while busy ignored (pc)", pc, 16'h00C4);
        check("R9 jump length unchanged", c, 3);
        @(negedge clk);
        check("R9 pc stable after", pc, 16'h00C4);
        check("R11 back to idle", {busy, done}, 2'b00);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'h00;
        end
        t_reset();
        t_load_hl();
        t_jump_taken();
        t_cond_matrix();
        t_call_ret_wrap();
        t_skips();
        t_nested();
        t_pc_wrap();
        t_busy_ignore();
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule